// File: doc/BRIEF.md
# Timer Up-Counter with Qualified Overflow

This block is the counting core of a timer/event unit. A run bit starts and stops a register that counts up by one on each cycle where a prescaled tick is high. While stopped, the register sits at all-ones. The first tick after a start moves it to zero, and that step counts as neither an overflow nor a clear. Four channels each hold a compare value. A channel pulses its match interrupt when the count equals its value. A selected channel can also act as the clear point, sending the count back to zero. Four capture triggers latch the count into per-channel capture registers. In pulse-width mode, a capture also clears the count.

A step from all-ones to zero that is neither the first step nor a clear sets a sticky overflow flag and gives a one-cycle overflow interrupt. Software clears the flag with a write strobe. A read port shows the live count while running and zero while stopped.

Top module: `evtmr_core`

## Requirements
- R1: After reset and while `run` is 0, the count register holds all-ones, `rd_count` reads 0, and `cmp_irq` and `ovf_irq` stay 0.
- R2: While `run` is 1, `rd_count` equals the live count.
- R3: With `run` at 1, the count changes only on a clock edge where `tick` is 1. It steps up by one from all-ones to zero and onward.
- R4: The first tick after a start (the step from all-ones to zero) raises no `cmp_irq` bit and no overflow, even if a compare value is all-ones.
- R5: When `clr_on_cmp` is 1 and the count equals the compare value of channel `clr_sel` on a tick, the count becomes 0 on that edge.
- R6: `cmp_irq[m]` is high for exactly the one cycle after a tick edge on which the count equaled `cmp_vals[16m+15:16m]`, except for the first step.
- R7: A tick with `cap_trig[m]` high loads the count as it was before that edge into `cap_vals[16m+15:16m]`. When `mode` is 1 (pulse width) this also clears the count to 0. When `mode` is 0 (free run) the count keeps stepping.
- R8: A tick step from all-ones to zero that is not the first step and not a clear sets `ovf_flag` and raises `ovf_irq` for one cycle, in either mode.
- R9: When `clr_on_cmp` is 1 and the selected compare value is all-ones, the return to zero is a clear and signals no overflow.
- R10: In pulse-width mode, a capture taken while the count is all-ones clears to zero and signals no overflow.
- R11: `ovf_flag` stays 1 until a cycle with `ovf_clr` high. If an overflow happens on that same edge, the flag stays 1.
- R12: When `run` is 0 on an edge, the count returns to all-ones. The next start again suppresses the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Count enable |
| tick | input | 1 | Prescaled count strobe |
| mode | input | 1 | 0 free run, 1 pulse-width measurement |
| clr_on_cmp | input | 1 | Enable clear on compare match |
| clr_sel | input | 2 | Channel whose compare value is the clear point |
| cmp_vals | input | 64 | Four compare values, channel m in bits 16m+15:16m |
| cap_trig | input | 4 | Qualified capture triggers, one per channel |
| ovf_clr | input | 1 | Software write strobe clearing the overflow flag |
| rd_count | output | 16 | Software-readable count |
| cap_vals | output | 64 | Four capture registers, same packing as cmp_vals |
| cmp_irq | output | 4 | Per-channel compare-match pulses |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest states to reach are the wrap edges. An overflow, a capture exactly at all-ones, and a compare clear at all-ones each need the count walked through its whole range. So the bench builds the block narrower and lets its reference model report when the count reaches all-ones. It then places the capture trigger, or the flag-clear strobe, on exactly that tick. A stop and restart in mid-count checks that the first-step suppression is armed again.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
   typedef enum logic {
      MODE_FREE   = 1'b0,
      MODE_PWIDTH = 1'b1
   } evtmr_mode_e;
endpackage

// File: rtl/evtmr_match.sv
module evtmr_match #(
   parameter int CNT_W = 16,
   parameter int NCH   = 4
) (
   input  logic [CNT_W-1:0]     count,
   input  logic [NCH*CNT_W-1:0] cmp_vals,
   output logic [NCH-1:0]       hit
);
   for (genvar m = 0; m < NCH; m++) begin : g_ch
      assign hit[m] = (count == cmp_vals[m*CNT_W +: CNT_W]);
   end
endmodule

// File: rtl/evtmr_capture.sv
module evtmr_capture #(
   parameter int CNT_W = 16,
   parameter int NCH   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic [NCH-1:0]       trig,
   input  logic [CNT_W-1:0]     count,
   output logic [NCH*CNT_W-1:0] cap_vals
);
   for (genvar m = 0; m < NCH; m++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cap_vals[m*CNT_W +: CNT_W] <= '0;
         else if (step && trig[m])
            cap_vals[m*CNT_W +: CNT_W] <= count;
      end
   end
endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             fresh,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] TOP = '1;

   assign wrap = run && tick && !fresh && !clr && (count == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= TOP;
         fresh <= 1'b1;
      end else if (!run) begin
         count <= TOP;
         fresh <= 1'b1;
      end else if (tick) begin
         count <= clr ? '0 : count + 1'b1;
         fresh <= 1'b0;
      end
   end
endmodule

// File: rtl/evtmr_irq.sv
module evtmr_irq #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step,
   input  logic           fresh,
   input  logic [NCH-1:0] hit,
   input  logic           wrap,
   input  logic           ovf_clr,
   output logic [NCH-1:0] cmp_irq,
   output logic           ovf_irq,
   output logic           ovf_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_irq  <= '0;
         ovf_irq  <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         cmp_irq <= (step && !fresh) ? hit : '0;
         ovf_irq <= wrap;
         if (wrap)
            ovf_flag <= 1'b1;
         else if (ovf_clr)
            ovf_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core #(
   parameter int CNT_W = 16,
   parameter int NCH   = 4,
   localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 tick,
   input  logic                 mode,
   input  logic                 clr_on_cmp,
   input  logic [SEL_W-1:0]     clr_sel,
   input  logic [NCH*CNT_W-1:0] cmp_vals,
   input  logic [NCH-1:0]       cap_trig,
   input  logic                 ovf_clr,
   output logic [CNT_W-1:0]     rd_count,
   output logic [NCH*CNT_W-1:0] cap_vals,
   output logic [NCH-1:0]       cmp_irq,
   output logic                 ovf_irq,
   output logic                 ovf_flag
);
   import evtmr_pkg::*;

   if (CNT_W < 2) begin : g_bad_w
      $error("evtmr_core: CNT_W must be at least 2");
   end
   if (NCH < 1) begin : g_bad_n
      $error("evtmr_core: NCH must be at least 1");
   end

   logic [CNT_W-1:0] count;
   logic             fresh;
   logic             wrap;
   logic [NCH-1:0]   hit;
   logic             sel_hit;
   logic             clr;
   logic             step;
   evtmr_mode_e      mode_e;

   assign mode_e  = evtmr_mode_e'(mode);
   assign step    = run && tick;
   assign sel_hit = (32'(clr_sel) < NCH) ? hit[clr_sel] : 1'b0;
   assign clr     = (clr_on_cmp && sel_hit)
                 || ((mode_e == MODE_PWIDTH) && (|cap_trig));
   assign rd_count = run ? count : '0;

   evtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .clr(clr),
      .count(count), .fresh(fresh), .wrap(wrap)
   );

   evtmr_match #(.CNT_W(CNT_W), .NCH(NCH)) u_match (
      .count(count), .cmp_vals(cmp_vals), .hit(hit)
   );

   evtmr_capture #(.CNT_W(CNT_W), .NCH(NCH)) u_cap (
      .clk(clk), .rst_n(rst_n), .step(step), .trig(cap_trig),
      .count(count), .cap_vals(cap_vals)
   );

   evtmr_irq #(.NCH(NCH)) u_irq (
      .clk(clk), .rst_n(rst_n), .step(step), .fresh(fresh), .hit(hit),
      .wrap(wrap), .ovf_clr(ovf_clr), .cmp_irq(cmp_irq),
      .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
   );
endmodule

// File: rtl/evtmr_core_chk.sv
module evtmr_core_chk #(
   parameter int CNT_W = 16,
   parameter int NCH   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] count,
   input logic             fresh,
   input logic [NCH-1:0]   cmp_irq,
   input logic             ovf_irq,
   input logic             ovf_flag
);
   a_r1_idle_top: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (count == {CNT_W{1'b1}}));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cmp_irq == '0) && !ovf_irq);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick |=> $stable(count));

   a_r4_first_step: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick && fresh |=> (count == '0) && !ovf_irq && (cmp_irq == '0));

   a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |=> !ovf_irq);

   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ovf_flag);

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag);

   a_r12_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> fresh);
endmodule

bind evtmr_core evtmr_core_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .ovf_clr(ovf_clr),
   .count(count), .fresh(fresh), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq),
   .ovf_flag(ovf_flag)
);

// File: tb/sim_evtmr_core.sv
module sim_evtmr_core;
   localparam int W   = 10;
   localparam int N   = 4;
   localparam int ALL = (1 << W) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           run = 1'b0, tick = 1'b0, mode = 1'b0, clr_on_cmp = 1'b0;
   logic [1:0]     clr_sel = 2'd0;
   logic [N*W-1:0] cmp_vals = '0;
   logic [N-1:0]   cap_trig = '0;
   logic           ovf_clr = 1'b0;
   logic [W-1:0]   rd_count;
   logic [N*W-1:0] cap_vals;
   logic [N-1:0]   cmp_irq;
   logic           ovf_irq, ovf_flag;

   evtmr_core #(.CNT_W(W), .NCH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .mode(mode),
      .clr_on_cmp(clr_on_cmp), .clr_sel(clr_sel), .cmp_vals(cmp_vals),
      .cap_trig(cap_trig), .ovf_clr(ovf_clr), .rd_count(rd_count),
      .cap_vals(cap_vals), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq),
      .ovf_flag(ovf_flag)
   );

   always #2 clk = ~clk;

   int    checks = 0, fails = 0, cycles = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // behavioural reference
   int e_cnt = ALL, e_flag = 0, e_ovi = 0, e_first = 1;
   int e_cmpi[N];
   int e_cap[N];
   initial for (int m = 0; m < N; m++) begin e_cmpi[m] = 0; e_cap[m] = 0; end

   always @(posedge clk) begin
      if (!rst_n) begin
         e_cnt = ALL; e_flag = 0; e_ovi = 0; e_first = 1;
         for (int m = 0; m < N; m++) begin e_cmpi[m] = 0; e_cap[m] = 0; end
      end else begin
         int wrapped;
         wrapped = 0;
         e_ovi = 0;
         for (int m = 0; m < N; m++) e_cmpi[m] = 0;
         if (!run) begin
            e_cnt = ALL; e_first = 1;
         end else if (tick) begin
            int cl;
            int cv;
            cv = cmp_vals[int'(clr_sel)*W +: W];
            cl = ((clr_on_cmp && e_cnt == cv) || (mode && cap_trig != 0)) ? 1 : 0;
            for (int m = 0; m < N; m++) begin
               if (!e_first && e_cnt == int'(cmp_vals[m*W +: W])) e_cmpi[m] = 1;
               if (cap_trig[m]) e_cap[m] = e_cnt;
            end
            if (!e_first && !cl && e_cnt == ALL) wrapped = 1;
            e_cnt = cl ? 0 : (e_cnt + 1) % (ALL + 1);
            e_first = 0;
         end
         e_ovi = wrapped;
         if (wrapped) e_flag = 1;
         else if (ovf_clr) e_flag = 0;
      end
   end

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rd_count, run ? e_cnt : 0, "rd_count (R2)");
         chk(ovf_irq, e_ovi, "ovf_irq (R8)");
         chk(ovf_flag, e_flag, "ovf_flag (R11)");
         for (int m = 0; m < N; m++) begin
            chk(cmp_irq[m], e_cmpi[m], "cmp_irq (R6)");
            chk(cap_vals[m*W +: W], e_cap[m], "cap_vals (R7)");
         end
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic run_to_top();
      int guard;
      guard = 0;
      while (e_cnt != ALL && guard < 4 * ALL) begin
         cyc(1); guard++;
      end
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish actual=%0d expected<150000", cycles);
         finish_up();
      end
   end

   initial begin
      cmp_vals[0*W +: W] = W'(ALL);
      cmp_vals[1*W +: W] = W'(5);
      cmp_vals[2*W +: W] = W'(7);
      cmp_vals[3*W +: W] = W'(300);
      cyc(3);
      rst_n = 1'b1;
      tag = "R1";
      cyc(4);

      tag = "R4"; run = 1'b1; tick = 1'b1;
      cyc(3);
      tag = "R3";
      for (int i = 0; i < 30; i++) begin
         tick = (i % 3 == 0); cyc(1);
      end

      tag = "R6"; tick = 1'b1;
      cyc(20);

      tag = "R5"; clr_on_cmp = 1'b1; clr_sel = 2'd2;
      cyc(30);

      tag = "R7"; clr_on_cmp = 1'b0; mode = 1'b0;
      for (int i = 0; i < 12; i++) begin
         cap_trig = (i % 4 == 1) ? 4'b0010 : 4'b0000; cyc(1);
      end
      mode = 1'b1;
      for (int i = 0; i < 12; i++) begin
         cap_trig = (i % 5 == 2) ? 4'b1001 : 4'b0000; cyc(1);
      end
      cap_trig = '0;

      tag = "R8"; mode = 1'b0;
      run_to_top();
      tag = "R11"; ovf_clr = 1'b1;
      cyc(1);
      ovf_clr = 1'b0;
      cyc(5);
      ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
      cyc(3);

      tag = "R10"; mode = 1'b1;
      run_to_top();
      cap_trig = 4'b1000; cyc(1); cap_trig = '0;
      cyc(5);

      tag = "R9"; mode = 1'b0; clr_on_cmp = 1'b1; clr_sel = 2'd0;
      run_to_top();
      cyc(10);

      tag = "R12"; clr_on_cmp = 1'b0;
      cyc(40);
      run = 1'b0; cyc(2);
      run = 1'b1; cyc(3);
      tick = 1'b0; cyc(3);
      run = 1'b0; cyc(1);
      run = 1'b1; tick = 1'b1; cyc(5);

      tag = "R1"; run = 1'b0;
      cyc(4);
      finish_up();
   end
endmodule